// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry Flag

This block shifts a 32-bit operand by an amount taken from another register. It supports four shift kinds: logical left, logical right, arithmetic right and rotate right. The datapath is combinational and returns two things: the shifted value, and the carry value that the flag would take after this operation.

The shift amount is the low byte of a 32-bit amount operand, so every amount from 0 to 255 is legal. Amounts of 32 and above follow exact rules for each kind. A zero amount leaves both the operand and the carry flag untouched, and the block signals this with a carry-update enable.

The carry flag register sits inside the block. It loads on a clock edge only when the operation is marked valid and the update enable is high.

Top module: `reg_shift_unit`

## Requirements
- R1: Only bits 7:0 of `amount_i` set the shift amount; bits 31:8 never change any output.
- R2: `kind_i` encodes 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right, 2'b11 rotate right. For amounts 1 to 31, `result_o` is the operand shifted by that amount: zeros fill logical shifts and the sign bit fills arithmetic right shifts.
- R3: For amounts 1 to 31, the carry is bit (32 - n) of the operand for a left shift, and bit (n - 1) for a logical or arithmetic right shift.
- R4: Logical left and logical right shifts by 32 to 255 give a result of zero.
- R5: A logical left shift by exactly 32 gives carry = operand bit 0. A logical right shift by exactly 32 gives carry = operand bit 31. Either logical shift by 33 to 255 gives carry 0.
- R6: An arithmetic right shift by 32 to 255 fills every result bit with operand bit 31, and the carry becomes operand bit 31.
- R7: Rotate right uses only amount bits 4:0. For a non-zero rotate count k, the carry is operand bit (k - 1), which is also result bit 31.
- R8: A rotate whose amount bits 4:0 are zero but whose full byte is non-zero returns the operand unchanged, sets the carry to operand bit 31, and asserts `carry_upd_o`.
- R9: An amount byte of zero returns the operand unchanged for every kind, drives `carry_upd_o` low, and drives `carry_o` equal to the current `carry_flag_o`.
- R10: `carry_flag_o` is reset to 0 by `rst_ni`. It loads `carry_o` on a rising clock edge only when `valid_i` and `carry_upd_o` are both high; otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation valid; allows the flag to update |
| kind_i | input | 2 | Shift kind code |
| data_i | input | 32 | Operand to shift |
| amount_i | input | 32 | Amount operand; only the low byte is used |
| result_o | output | 32 | Shifted value |
| carry_o | output | 1 | Carry value the flag takes after this operation |
| carry_upd_o | output | 1 | High when this operation writes the carry flag |
| carry_flag_o | output | 1 | Registered carry flag |

## Verification
The only state in the block is the carry flag. If the flag is loaded wrongly, or fails to hold on a zero amount or an invalid cycle, `carry_flag_o` is wrong from the very next edge. The error also appears on `carry_o` during the next zero-amount operation, because that output then passes the flag through. The bench keeps a reference model of the flag and compares it on every cycle, so a bad flag is caught one cycle after the edge that corrupted it. The datapath has no state, so an error in it shows up on `result_o` and `carry_o` in the same cycle as the stimulus.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/shift_amt_decode.sv
module shift_amt_decode #(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input  logic [AMT_W-1:0]         amt_i,
  output logic                     zero_o,
  output logic                     eq_w_o,
  output logic                     ge_w_o,
  output logic [$clog2(WIDTH)-1:0] rot_o
);
  localparam logic [AMT_W-1:0] W_AMT = AMT_W'(WIDTH);
  assign zero_o = (amt_i == '0);
  assign eq_w_o = (amt_i == W_AMT);
  assign ge_w_o = (amt_i >= W_AMT);
  assign rot_o  = amt_i[$clog2(WIDTH)-1:0];
endmodule

// File: rtl/shift_core.sv
module shift_core
  import shift_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input  shift_kind_e              kind_i,
  input  logic [WIDTH-1:0]         data_i,
  input  logic [AMT_W-1:0]         amt_i,
  input  logic                     ge_w_i,
  input  logic [$clog2(WIDTH)-1:0] rot_i,
  output logic [WIDTH-1:0]         result_o,
  output logic                     carry_o
);
  localparam logic [AMT_W-1:0] W_AMT = AMT_W'(WIDTH);

  logic [WIDTH:0]          lsl_w, lsr_w, asr_w;
  logic signed [WIDTH:0]   asr_src;
  logic [AMT_W-1:0]        asr_amt;
  logic [2*WIDTH-1:0]      ror_w;

  // extra bit on the shifted-out side carries the last bit lost
  assign lsl_w   = {1'b0, data_i} << amt_i;
  assign lsr_w   = {data_i, 1'b0} >> amt_i;
  assign asr_src = $signed({data_i, 1'b0});
  assign asr_amt = ge_w_i ? W_AMT : amt_i;
  assign asr_w   = (WIDTH+1)'(asr_src >>> asr_amt);
  assign ror_w   = {data_i, data_i} >> rot_i;

  always_comb begin
    unique case (kind_i)
      SK_LSL: begin result_o = lsl_w[WIDTH-1:0];  carry_o = lsl_w[WIDTH]; end
      SK_LSR: begin result_o = lsr_w[WIDTH:1];    carry_o = lsr_w[0];     end
      SK_ASR: begin result_o = asr_w[WIDTH:1];    carry_o = asr_w[0];     end
      default: begin
        result_o = ror_w[WIDTH-1:0];
        carry_o  = ror_w[WIDTH-1]; // msb of rotated value, also for k==0
      end
    endcase
  end
endmodule

// File: rtl/carry_flag_reg.sv
module carry_flag_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (load_i) q_o <= d_i;
  end

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o));
  a_r10_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (q_o == $past(d_i)));
endmodule

// File: rtl/reg_shift_unit.sv
module reg_shift_unit
  import shift_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       kind_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] amount_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             carry_upd_o,
  output logic             carry_flag_o
);
  localparam int RW = $clog2(WIDTH);
  localparam logic [AMT_W-1:0] W_AMT = AMT_W'(WIDTH);

  logic [AMT_W-1:0] amt;
  logic             amt_zero, amt_eq_w, amt_ge_w;
  logic [RW-1:0]    rot;
  logic             carry_new;
  shift_kind_e      kind;

  assign amt  = amount_i[AMT_W-1:0];
  assign kind = shift_kind_e'(kind_i);

  shift_amt_decode #(.WIDTH(WIDTH), .AMT_W(AMT_W)) i_dec (
    .amt_i (amt),
    .zero_o(amt_zero),
    .eq_w_o(amt_eq_w),
    .ge_w_o(amt_ge_w),
    .rot_o (rot)
  );

  shift_core #(.WIDTH(WIDTH), .AMT_W(AMT_W)) i_core (
    .kind_i  (kind),
    .data_i  (data_i),
    .amt_i   (amt),
    .ge_w_i  (amt_ge_w),
    .rot_i   (rot),
    .result_o(result_o),
    .carry_o (carry_new)
  );

  assign carry_upd_o = !amt_zero;
  assign carry_o     = carry_upd_o ? carry_new : carry_flag_o;

  carry_flag_reg i_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(valid_i && carry_upd_o),
    .d_i   (carry_o),
    .q_o   (carry_flag_o)
  );

  a_r9_zero_amt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (amount_i[AMT_W-1:0] == '0) |-> (result_o == data_i && !carry_upd_o && carry_o == carry_flag_o));
  a_r4_r5_logical_big: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i != 2'b10 && kind_i != 2'b11 && amount_i[AMT_W-1:0] > W_AMT) |-> (result_o == '0 && carry_o == 1'b0));
  a_r6_asr_big: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == 2'b10 && amount_i[AMT_W-1:0] >= W_AMT) |-> (result_o == {WIDTH{data_i[WIDTH-1]}} && carry_o == data_i[WIDTH-1]));
  a_r8_ror_multiple: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == 2'b11 && amount_i[RW-1:0] == '0 && amount_i[AMT_W-1:0] != '0) |-> (result_o == data_i && carry_o == data_i[WIDTH-1] && carry_upd_o));
  a_r7_ror_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == 2'b11 && carry_upd_o) |-> (carry_o == result_o[WIDTH-1]));
endmodule

// File: tb/test_reg_shift_unit.sv
module test_reg_shift_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  kind = 2'b00;
  logic [31:0] data = '0, amount = '0;
  logic [31:0] result;
  logic        carry, upd, flag;
  int          errors = 0, checks = 0;
  bit          exp_flag = 1'b0;

  always #5 clk = ~clk;

  reg_shift_unit i_reg_shift_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .kind_i(kind),
    .data_i(data), .amount_i(amount), .result_o(result), .carry_o(carry),
    .carry_upd_o(upd), .carry_flag_o(flag)
  );

  task automatic model(input logic [1:0] k, input logic [31:0] d, input logic [31:0] a,
                       output logic [31:0] r, output bit c, output bit u);
    int n = int'(a[7:0]);
    r = d; c = exp_flag; u = (n != 0);
    case (k)
      2'b00: for (int i = 0; i < n; i++) begin c = r[31]; r = r << 1; end
      2'b01: for (int i = 0; i < n; i++) begin c = r[0]; r = r >> 1; end
      2'b10: for (int i = 0; i < n; i++) begin c = r[0]; r = {r[31], r[31:1]}; end
      default: if (n != 0) begin
        if (n % 32 == 0) c = d[31];
        else for (int i = 0; i < n % 32; i++) begin c = r[0]; r = {r[0], r[31:1]}; end
      end
    endcase
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [1:0] k, input logic [31:0] d,
                      input logic [31:0] a, input logic v);
    logic [31:0] er; bit ec, eu;
    @(negedge clk);
    kind = k; data = d; amount = a; valid = v;
    model(k, d, a, er, ec, eu);
    #1;
    chk(tag, "result", result, er);
    chk(tag, "carry", 32'(carry), 32'(ec));
    chk(tag, "upd", 32'(upd), 32'(eu));
    chk("R10", "flag", 32'(flag), 32'(exp_flag));
    @(posedge clk);
    if (v && eu) exp_flag = ec;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #12;
    chk("R10", "reset flag", 32'(flag), 32'h0);
    rst_n = 1'b1;
    // R2 / R3 basic kinds
    step("R2", 2'b00, 32'h8000_0001, 32'd1, 1'b1);
    step("R3", 2'b00, 32'h1234_5678, 32'd4, 1'b1);
    step("R3", 2'b01, 32'h0000_0003, 32'd2, 1'b1);
    step("R2", 2'b10, 32'h8000_00F0, 32'd4, 1'b1);
    step("R3", 2'b10, 32'h7FFF_FFFF, 32'd31, 1'b1);
    // R9 zero amount, flag passes through
    step("R9", 2'b00, 32'hDEAD_BEEF, 32'd0, 1'b1);
    step("R9", 2'b11, 32'h0F0F_0F0F, 32'hFFFF_FF00, 1'b1);
    // R1 upper bits ignored
    step("R1", 2'b01, 32'hF000_0000, 32'hABCD_EF04, 1'b1);
    step("R1", 2'b00, 32'hFFFF_FFFF, 32'h0000_0100, 1'b1);
    // R4 / R5 logical big
    step("R5", 2'b00, 32'h0000_0001, 32'd32, 1'b1);
    step("R5", 2'b01, 32'h8000_0000, 32'd32, 1'b1);
    step("R4", 2'b00, 32'hFFFF_FFFF, 32'd33, 1'b1);
    step("R5", 2'b01, 32'hFFFF_FFFF, 32'd255, 1'b1);
    // R6 asr big
    step("R6", 2'b10, 32'h8000_0000, 32'd32, 1'b1);
    step("R6", 2'b10, 32'h7000_0001, 32'd200, 1'b1);
    step("R6", 2'b10, 32'hC000_0000, 32'd255, 1'b1);
    // R7 / R8 rotate
    step("R7", 2'b11, 32'h0000_0001, 32'd1, 1'b1);
    step("R7", 2'b11, 32'h1234_5678, 32'd37, 1'b1);
    step("R8", 2'b11, 32'h8000_0000, 32'd32, 1'b1);
    step("R8", 2'b11, 32'h1111_1111, 32'd64, 1'b1);
    // R10 invalid cycles do not load
    step("R10", 2'b00, 32'h0000_0001, 32'd32, 1'b0);
    step("R10", 2'b01, 32'h0000_0001, 32'd1, 1'b0);
    step("R10", 2'b00, 32'h0000_0000, 32'd5, 1'b1);
    for (int i = 0; i < 400; i++)
      step("R2", 2'($urandom), $urandom, (i % 3 == 0) ? $urandom : 32'($urandom % 70), 1'($urandom));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule